// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block is the switching core of a time-division multiplexed exchange. It works on channel bytes that have already been converted from serial form. During each frame (125 µs in the target system, which carries 32, 64, 128 or 256 channels per stream at 2.048, 4.096, 8.192 or 16.384 Mbps) the byte of every input stream in every channel slot is written into a data memory with two banks. For each output stream and channel slot, a connection word decides what that slot carries. It can carry a byte taken from any source stream and channel, or a message byte stored inside the word itself. It can also carry nothing, and then a per-slot high-impedance flag is raised so that external drivers can release the line.

Slot timing follows a control state machine with two states. In `ST_WAIT_SYNC`, entered at reset, no data is stored and every output is flagged high-impedance. The transition `sync_seen` moves it to `ST_RUN` on the first `frame_sync` pulse. `ST_RUN` has a single transition, `stay_run`, back to itself. In that state one slot is processed per clock, and a frame boundary occurs either on a `frame_sync` pulse or when the slot count passes the last channel. At every boundary the two data banks swap roles, and all connection words written since the previous boundary become active together.

A simple register port writes connection words into a staging copy and reads them back. Each channel has its own delay mode: constant, which is always exactly one frame, or variable, which is the shortest delay the source position allows. Variable delay depends on a global enable.

Top module: `tsi_switch`

## Requirements
- R1: From reset until the first `frame_sync`, every `out_hiz` bit is 1, every output byte is 0, and input bytes are not stored.
- R2: `frame_sync` high in a cycle makes that cycle slot 0. Later cycles are slots 1, 2, and so on. After slot NCH-1 the count returns to slot 0 and starts a new frame even when no `frame_sync` arrives.
- R3: Connection word fields: bit 15 enables the output slot, bit 14 selects variable delay, bit 0 selects message mode. In switching mode, bits 3:1 hold the source channel and bits 5:4 hold the source stream (default sizes). With bit 14 clear, output slot n of frame k carries the byte the source received in frame k-1.
- R4: In variable delay with the global enable set, a source channel m below the output slot n gives the byte received in the same frame.
- R5: In variable delay with the global enable set, a source channel m at or above n gives the byte received in the previous frame, a delay of one frame minus (m-n) slots.
- R6: A word with variable delay selected while `var_en` is 0 gives an output slot with `out_hiz` set and data 0.
- R7: With bit 0 set, the output slot carries bits 8:1 of the word as its byte, whatever the delay setting and `var_en` are.
- R8: With bit 15 clear, the output slot has `out_hiz` set and data 0.
- R9: A connection write appears on `cm_rdata` (address = {stream, channel}) in the next cycle, but changes the output only from the next frame boundary onward.
- R10: The result for slot n is registered and appears on the outputs in the cycle after slot n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one channel slot per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_sync | input | 1 | Marks the current cycle as slot 0 |
| var_en | input | 1 | Global permission for variable delay |
| in_data | input | NS*8 | Current slot byte of each input stream, stream s at bits 8s+7:8s |
| cm_we | input | 1 | Connection word write strobe |
| cm_addr | input | SW+CW | Connection address {output stream, channel} |
| cm_wdata | input | 16 | Connection word to write |
| cm_rdata | output | 16 | Staged connection word at cm_addr |
| out_data | output | NS*8 | Output byte of each stream, registered |
| out_hiz | output | NS | Per-stream high-impedance flag for the slot |

## Verification
The bench uses two variable-delay mappings whose source channel lies above the output slot in some slots and below it in others. A design that compared the wrong way, or that read the bank being written for an equal channel, would return current-frame bytes where previous-frame bytes are expected. A connection word is rewritten in the middle of a frame for a slot that has not yet been reached in that frame. A design that applied the change at once would show the new message byte one frame too early. One frame runs with `var_en` low, which must flag every variable channel as high-impedance while constant and message channels continue unchanged. A final frame wraps without `frame_sync`. A design that swapped banks only on the pulse would replay stale bytes in that frame.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
    typedef enum logic {
        ST_WAIT_SYNC = 1'b0,
        ST_RUN       = 1'b1
    } tsi_state_e;

    localparam int CWORD_W   = 16;
    localparam int BIT_EN    = 15;
    localparam int BIT_VAR   = 14;
    localparam int BIT_MSG   = 0;
    localparam int MSG_LSB   = 1;
endpackage

// File: rtl/tsi_ctrl.sv
module tsi_ctrl
    import tsi_pkg::*;
#(
    parameter int NCH = 8,
    localparam int CW = $clog2(NCH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_sync,
    output logic          running,
    output logic          boundary,
    output logic [CW-1:0] cur_slot,
    output logic          wr_bank
);
    tsi_state_e    state_q, state_d;
    logic [CW-1:0] slot_q;
    logic          bank_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT_SYNC;
            slot_q  <= CW'(NCH - 1);
            bank_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (running) slot_q <= cur_slot;
            if (boundary) bank_q <= ~bank_q;
        end
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        running  = 1'b0;
        boundary = frame_sync;
        unique case (state_q)
            ST_WAIT_SYNC: begin
                running = frame_sync;
                if (frame_sync) state_d = ST_RUN;       // sync_seen
            end
            ST_RUN: begin
                running = 1'b1;
                if (slot_q == CW'(NCH - 1)) boundary = 1'b1;
                state_d = ST_RUN;                       // stay_run
            end
        endcase
        cur_slot = boundary ? '0 : slot_q + CW'(1);
        wr_bank  = boundary ? ~bank_q : bank_q;
    end

    // R2: a sync pulse restarts the slot count
    p_sync_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> (slot_q == '0));

    // R2: without sync the count steps by one each cycle in ST_RUN
    p_slot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !frame_sync && slot_q != CW'(NCH - 1))
            |=> (slot_q == $past(slot_q) + CW'(1)));

    // R1: no slot advance while waiting for the first sync
    p_wait_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_SYNC && !frame_sync) |=> $stable(slot_q));
endmodule

// File: rtl/tsi_dmem.sv
module tsi_dmem #(
    parameter int NS  = 4,
    parameter int NCH = 8,
    localparam int SW = (NS > 1) ? $clog2(NS) : 1,
    localparam int CW = $clog2(NCH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic                    wbank,
    input  logic [CW-1:0]           wslot,
    input  logic [NS*8-1:0]         wdata,
    input  logic [NS-1:0]           rbank,
    input  logic [NS-1:0][SW-1:0]   rstream,
    input  logic [NS-1:0][CW-1:0]   rslot,
    output logic [NS-1:0][7:0]      rdata
);
    logic [7:0] mem_q [2][NS][NCH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++)
                for (int s = 0; s < NS; s++)
                    for (int c = 0; c < NCH; c++)
                        mem_q[b][s][c] <= '0;
        end else if (we) begin
            for (int s = 0; s < NS; s++)
                mem_q[wbank][s][wslot] <= wdata[s*8 +: 8];
        end
    end

    for (genvar o = 0; o < NS; o++) begin : g_rd
        assign rdata[o] = mem_q[rbank[o]][rstream[o]][rslot[o]];
    end
endmodule

// File: rtl/tsi_cmem.sv
module tsi_cmem
    import tsi_pkg::*;
#(
    parameter int NS  = 4,
    parameter int NCH = 8,
    localparam int SW = (NS > 1) ? $clog2(NS) : 1,
    localparam int CW = $clog2(NCH),
    localparam int AW = SW + CW,
    localparam int DEPTH = 1 << AW
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [AW-1:0]              addr,
    input  logic [CWORD_W-1:0]         wr_data,
    output logic [CWORD_W-1:0]         rd_data,
    input  logic                       boundary,
    input  logic [CW-1:0]              slot,
    output logic [NS-1:0][CWORD_W-1:0] sel_word
);
    logic [DEPTH-1:0][CWORD_W-1:0] staged_q;
    logic [DEPTH-1:0][CWORD_W-1:0] active_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            staged_q <= '0;
            active_q <= '0;
        end else begin
            if (wr_en) staged_q[addr] <= wr_data;
            if (boundary) active_q <= staged_q;
        end
    end

    assign rd_data = staged_q[addr];

    for (genvar o = 0; o < NS; o++) begin : g_sel
        assign sel_word[o] = boundary ? staged_q[{SW'(o), slot}]
                                      : active_q[{SW'(o), slot}];
    end

    // R9: the active mapping never changes inside a frame
    p_hold_mapping_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(active_q));
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int NS  = 4,
    parameter int NCH = 8,
    localparam int SW = (NS > 1) ? $clog2(NS) : 1,
    localparam int CW = $clog2(NCH),
    localparam int AW = SW + CW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_sync,
    input  logic               var_en,
    input  logic [NS*8-1:0]    in_data,
    input  logic               cm_we,
    input  logic [AW-1:0]      cm_addr,
    input  logic [15:0]        cm_wdata,
    output logic [15:0]        cm_rdata,
    output logic [NS*8-1:0]    out_data,
    output logic [NS-1:0]      out_hiz
);
    logic                       running, boundary, wr_bank;
    logic [CW-1:0]              cur_slot;
    logic [NS-1:0][CWORD_W-1:0] sel_word;
    logic [NS-1:0]              rbank;
    logic [NS-1:0][SW-1:0]      rstream;
    logic [NS-1:0][CW-1:0]      rslot;
    logic [NS-1:0][7:0]         rdata;
    logic [NS-1:0][7:0]         nxt_data;
    logic [NS-1:0]              nxt_hiz;

    tsi_ctrl #(.NCH(NCH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
        .running(running), .boundary(boundary),
        .cur_slot(cur_slot), .wr_bank(wr_bank)
    );

    tsi_cmem #(.NS(NS), .NCH(NCH)) u_cmem (
        .clk(clk), .rst_n(rst_n), .wr_en(cm_we), .addr(cm_addr),
        .wr_data(cm_wdata), .rd_data(cm_rdata), .boundary(boundary),
        .slot(cur_slot), .sel_word(sel_word)
    );

    tsi_dmem #(.NS(NS), .NCH(NCH)) u_dmem (
        .clk(clk), .rst_n(rst_n), .we(running), .wbank(wr_bank),
        .wslot(cur_slot), .wdata(in_data), .rbank(rbank),
        .rstream(rstream), .rslot(rslot), .rdata(rdata)
    );

    always_comb begin
        for (int o = 0; o < NS; o++) begin
            rstream[o]  = sel_word[o][CW+SW:CW+1];
            rslot[o]    = sel_word[o][CW:1];
            // variable delay reads this frame's bank for already-passed sources
            rbank[o]    = (sel_word[o][BIT_VAR] && (rslot[o] < cur_slot))
                          ? wr_bank : ~wr_bank;
            nxt_hiz[o]  = 1'b1;
            nxt_data[o] = '0;
            if (running && sel_word[o][BIT_EN]) begin
                if (sel_word[o][BIT_MSG]) begin
                    nxt_hiz[o]  = 1'b0;
                    nxt_data[o] = sel_word[o][MSG_LSB+7:MSG_LSB];
                end else if (!sel_word[o][BIT_VAR] || var_en) begin
                    nxt_hiz[o]  = 1'b0;
                    nxt_data[o] = rdata[o];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_hiz  <= '1;
            out_data <= '0;
        end else begin
            out_hiz  <= nxt_hiz;
            out_data <= nxt_data;
        end
    end

    // R1: idle cycles produce only high-impedance slots
    p_idle_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> (&out_hiz && out_data == '0));

    for (genvar o = 0; o < NS; o++) begin : g_chk
        // R6: variable delay without the global enable is flagged
        p_var_off_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (running && sel_word[o][BIT_EN] && !sel_word[o][BIT_MSG]
             && sel_word[o][BIT_VAR] && !var_en) |=> out_hiz[o]);
        // R8: a disabled slot carries no data
        p_disabled_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (running && !sel_word[o][BIT_EN])
                |=> (out_hiz[o] && out_data[o*8 +: 8] == 8'h00));
    end
endmodule

// File: tb/tsi_switch_bench.sv
module tsi_switch_bench;
    localparam int NS  = 4;
    localparam int NCH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_sync = 1'b0;
    logic        var_en = 1'b1;
    logic [31:0] in_data = '0;
    logic        cm_we = 1'b0;
    logic [4:0]  cm_addr = '0;
    logic [15:0] cm_wdata = '0;
    logic [15:0] cm_rdata;
    logic [31:0] out_data;
    logic [3:0]  out_hiz;

    int checks = 0;
    int fails  = 0;
    int fidx   = 0;
    logic [15:0] cfg_sh  [NS][NCH];
    logic [15:0] cfg_act [NS][NCH];

    always #4 clk = ~clk;

    tsi_switch u_tsi_switch (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .var_en(var_en),
        .in_data(in_data), .cm_we(cm_we), .cm_addr(cm_addr),
        .cm_wdata(cm_wdata), .cm_rdata(cm_rdata),
        .out_data(out_data), .out_hiz(out_hiz)
    );

    function automatic logic [7:0] dval(int k, int s, int c);
        if (k < 0) return 8'h00;
        return {1'b1, 2'(k), 2'(s), 3'(c)};
    endfunction

    function automatic logic [15:0] w_sw(bit en, bit vr, int s, int m);
        return {en, vr, 8'h00, 2'(s), 3'(m), 1'b0};
    endfunction

    function automatic logic [15:0] w_msg(bit en, logic [7:0] b);
        return {en, 1'b0, 5'h00, b, 1'b1};
    endfunction

    task automatic check(string tag, bit ok, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_out(string pre, int o, int c);
        logic [15:0] w;
        logic        eh;
        logic [7:0]  ed;
        string       tag;
        int          m;
        w  = cfg_act[o][c];
        eh = 1'b0;
        ed = 8'h00;
        m  = int'(w[3:1]);
        if (!w[15]) begin
            eh = 1'b1; tag = "R8";
        end else if (w[0]) begin
            ed = w[8:1]; tag = "R7";
        end else if (w[14] && !var_en) begin
            eh = 1'b1; tag = "R6";
        end else if (w[14] && m < c) begin
            ed = dval(fidx, int'(w[5:4]), m); tag = "R4";
        end else if (w[14]) begin
            ed = dval(fidx - 1, int'(w[5:4]), m); tag = "R5";
        end else begin
            ed = dval(fidx - 1, int'(w[5:4]), m); tag = "R3";
        end
        check({pre, tag}, out_hiz[o] == eh,
              $sformatf("hiz o=%0d slot=%0d frame=%0d", o, c, fidx),
              int'(out_hiz[o]), int'(eh));
        check({pre, tag, "+R10"}, out_data[o*8 +: 8] == ed,
              $sformatf("data o=%0d slot=%0d frame=%0d", o, c, fidx),
              int'(out_data[o*8 +: 8]), int'(ed));
    endtask

    // one slot; entered and left at a falling edge
    task automatic run_slot(string pre, bit sync, int c, bit wr,
                            int wo, int wc, logic [15:0] wd);
        if (c == 0) begin
            for (int o = 0; o < NS; o++)
                for (int k = 0; k < NCH; k++)
                    cfg_act[o][k] = cfg_sh[o][k];
        end
        frame_sync = sync;
        for (int s = 0; s < NS; s++) in_data[s*8 +: 8] = dval(fidx, s, c);
        cm_we    = wr;
        cm_addr  = {2'(wo), 3'(wc)};
        cm_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        frame_sync = 1'b0;
        cm_we      = 1'b0;
        if (wr) begin
            cfg_sh[wo][wc] = wd;
            check("R9", cm_rdata == wd, "mid-frame readback",
                  int'(cm_rdata), int'(wd));
        end
        for (int o = 0; o < NS; o++) check_out(pre, o, c);
    endtask

    task automatic run_frame(string pre, bit sync, int wslot,
                             int wo, int wc, logic [15:0] wd);
        for (int c = 0; c < NCH; c++)
            run_slot(pre, (c == 0) && sync, c, c == wslot, wo, wc, wd);
        fidx++;
    endtask

    task automatic cm_write(int o, int c, logic [15:0] w);
        cm_we    = 1'b1;
        cm_addr  = {2'(o), 3'(c)};
        cm_wdata = w;
        @(posedge clk);
        @(negedge clk);
        cm_we = 1'b0;
        cfg_sh[o][c] = w;
        check("R9", cm_rdata == w, $sformatf("readback o=%0d c=%0d", o, c),
              int'(cm_rdata), int'(w));
        check("R1", out_hiz == 4'hF, "hiz during config", int'(out_hiz), 15);
    endtask

    task automatic t_reset_state();
        check("R1", out_hiz == 4'hF, "hiz after reset", int'(out_hiz), 15);
        check("R1", out_data == 32'h0, "data after reset", int'(out_data), 0);
        check("R9", cm_rdata == 16'h0, "cm after reset", int'(cm_rdata), 0);
    endtask

    task automatic t_wait_no_sync();
        for (int i = 0; i < 3; i++) begin
            in_data = 32'hDEAD_BEEF;
            @(posedge clk);
            @(negedge clk);
            check("R1", out_hiz == 4'hF, "hiz before sync", int'(out_hiz), 15);
            check("R1", out_data == 32'h0, "data before sync", int'(out_data), 0);
        end
    endtask

    task automatic t_config();
        for (int c = 0; c < NCH; c++) begin
            cm_write(0, c, w_sw(1'b1, 1'b0, 2, (c + 3) % NCH));
            cm_write(1, c, w_sw(1'b1, 1'b1, 1, NCH - 1 - c));
            cm_write(2, c, w_msg(1'b1, 8'hA0 | 8'(c)));
        end
        cm_write(3, 0, w_sw(1'b1, 1'b1, 0, 0));
        cm_write(3, 1, w_sw(1'b1, 1'b0, 3, 1));
    endtask

    task automatic t_frames_basic();
        var_en = 1'b1;
        run_frame("", 1'b1, -1, 0, 0, 16'h0);
        run_frame("", 1'b1, -1, 0, 0, 16'h0);
    endtask

    task automatic t_midframe_update();
        // slot 7 not yet reached when slot 3 writes it: old byte stays this frame
        run_frame("", 1'b1, 3, 2, 7, w_msg(1'b1, 8'h3C));
    endtask

    task automatic t_var_disabled();
        var_en = 1'b0;
        run_frame("", 1'b1, -1, 0, 0, 16'h0);
        var_en = 1'b1;
    endtask

    task automatic t_free_wrap();
        run_frame("R2+", 1'b0, -1, 0, 0, 16'h0);
    endtask

    initial begin
        for (int o = 0; o < NS; o++)
            for (int c = 0; c < NCH; c++) begin
                cfg_sh[o][c]  = 16'h0;
                cfg_act[o][c] = 16'h0;
            end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_wait_no_sync();
        t_config();
        t_frames_basic();
        t_midframe_update();
        t_var_disabled();
        t_free_wrap();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule